// File: doc/BRIEF.md
# Priority Interrupt Requester with Acknowledge Chain

This block sits on a card that shares a backplane priority interrupt bus. When its local logic reports an event, it pulls down one of seven active-low request lines, the one chosen by a configured level from 1 to 7. Level 0 disables the block. Several cards may pull the same line at once. The handler answers with an acknowledge that travels from card to card down a daisy chain. A 3-bit level code on the low address lines comes with it.

The acknowledge input is asynchronous, so the block samples it through a two-flop synchronizer. A card responds to the acknowledge only when the acknowledged level equals its own level and it has a request outstanding. In that case it keeps the acknowledge from travelling further, drives its status/ID onto the data lines and pulls data acknowledge low. The status/ID has the logical address in bits 7..0, a cause code in bits 15..8 and device-specific bits in 31..16. In every other case the card passes the acknowledge to the next card. The request drops at the moment the card takes the acknowledge. A local event that arrives while an acknowledge is in progress waits until that acknowledge is over.

Top module: `irqc_top`

## Requirements
- R1: While and after reset, all request lines are high, ack_out_n and dtack_n are high, data_oe is 0 and data_o is 0.
- R2: One clock edge after event_i is sampled high with cfg_level L in 1..7 and no acknowledge in progress, irq_n bit L-1 is low and every other bit is high. With cfg_level 0, no line is pulled low.
- R3: When ack_in_n falls, ack_lvl equals a nonzero cfg_level and a request is outstanding, dtack_n goes low and data_oe goes high after the third rising edge, and ack_out_n stays high.
- R4: When ack_in_n falls with a different level or no request outstanding, ack_out_n goes low after the third rising edge, and dtack_n and data_oe stay inactive.
- R5: While the block is responding, data_o carries cfg_laddr in bits 7..0. It carries cfg_cause in bits 15..8 when ID_W is 16 or more, and cfg_devdep in bits 31..16 when ID_W is 32.
- R6: The request line is released at the same edge at which the block starts responding. It stays released unless a new event arrives.
- R7: Two rising edges after ack_in_n rises, dtack_n, ack_out_n and data_oe are all inactive.
- R8: An event that arrives while an acknowledge is in progress leaves the request lines unchanged until that acknowledge ends. The request line is pulled low on the fourth rising edge after ack_in_n rises.
- R9: data_o is zero whenever data_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 3 | Own request level, 0 disables |
| cfg_laddr | input | 8 | Logical address for status/ID bits 7..0 |
| cfg_cause | input | 8 | Cause code for status/ID bits 15..8 |
| cfg_devdep | input | 16 | Device-specific bits 31..16 |
| event_i | input | 1 | Local service event, one-cycle pulse |
| ack_in_n | input | 1 | Incoming acknowledge chain, active low, asynchronous |
| ack_lvl | input | 3 | Level under acknowledge |
| irq_n | output | 7 | Request lines 1..7, low pulls the line |
| ack_out_n | output | 1 | Acknowledge passed to the next card, active low |
| data_o | output | ID_W | Status/ID value |
| data_oe | output | 1 | Data line driver enable |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
Suppose the block wrongly believes a request is outstanding, or wrongly believes it is not. Then on the next acknowledge of its level it either responds or forwards by mistake. That shows at ack_out_n and dtack_n three edges after ack_in_n falls. A synchronizer stage lost or added moves all of these edges by one cycle, and the bench checks the exact cycles. An event wrongly dropped or released early during an acknowledge shows on irq_n within four edges of the release.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_RESP = 2'd2
  } chain_state_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqc_request.sv
module irqc_request #(
  parameter int NUM_LINES = 7,
  localparam int LVL_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_W-1:0]     cfg_level,
  input  logic                 event_i,
  input  logic                 busy_i,
  input  logic                 grant_i,
  output logic                 pending_o,
  output logic [NUM_LINES-1:0] irq_n
);
  logic pend_q, pend_d, defer_q, defer_d;
  logic pend_en, defer_en;

  always_comb begin
    pend_d   = pend_q;
    defer_d  = defer_q;
    if (grant_i) pend_d = 1'b0;
    if (event_i) begin
      if (busy_i) defer_d = 1'b1;
      else        pend_d  = 1'b1;
    end
    if (!busy_i && defer_q) begin
      pend_d  = 1'b1;
      defer_d = 1'b0;
    end
    pend_en  = (pend_d != pend_q);
    defer_en = (defer_d != defer_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      defer_q <= 1'b0;
    end else begin
      if (pend_en)  pend_q  <= pend_d;
      if (defer_en) defer_q <= defer_d;
    end
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign irq_n[k] = !(pend_q && (cfg_level == LVL_W'(k + 1)));
  end

  assign pending_o = pend_q;

  // R8: no request can appear while an acknowledge is in progress
  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !pend_q) |=> !pend_q);
  // R2: at most one line pulled
  a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1);
endmodule

// File: rtl/irqc_ack_fsm.sv
module irqc_ack_fsm #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_s,
  input  logic [LVL_W-1:0] ack_lvl,
  input  logic [LVL_W-1:0] cfg_level,
  input  logic             pending_i,
  output logic             grant_o,
  output logic             busy_o,
  output logic             resp_o,
  output logic             fwd_o
);
  import irqc_pkg::*;
  chain_state_e state_q, state_d;
  logic own_level;

  always_comb begin
    own_level = (ack_lvl == cfg_level) && (cfg_level != '0);
    state_d   = state_q;
    grant_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (ack_s) begin
        if (pending_i && own_level) begin
          state_d = ST_RESP;
          grant_o = 1'b1;
        end else begin
          state_d = ST_FWD;
        end
      end
      ST_FWD:  if (!ack_s) state_d = ST_IDLE;
      ST_RESP: if (!ack_s) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy_o = ack_s || (state_q != ST_IDLE);
  assign resp_o = (state_q == ST_RESP) && ack_s;
  assign fwd_o  = (state_q == ST_FWD)  && ack_s;

  // R4: a forwarded acknowledge never turns into a response
  a_r4_fwd_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FWD) |=> (state_q != ST_RESP));
  // R3: response only entered while a request was outstanding
  a_r3_resp_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && state_d == ST_RESP) |-> pending_i);
endmodule

// File: rtl/irqc_status_fmt.sv
module irqc_status_fmt #(
  parameter int ID_W = 32
) (
  input  logic [7:0]      laddr,
  input  logic [7:0]      cause,
  input  logic [15:0]     devdep,
  input  logic            drive_i,
  output logic [ID_W-1:0] data_o
);
  logic [ID_W-1:0] id_word;

  if (ID_W == 8) begin : g_w8
    assign id_word = laddr;
  end else if (ID_W == 16) begin : g_w16
    assign id_word = {cause, laddr};
  end else begin : g_w32
    assign id_word = {devdep, cause, laddr};
  end

  assign data_o = drive_i ? id_word : '0;

  initial begin
    a_r5_width_legal: assert (ID_W == 8 || ID_W == 16 || ID_W == 32);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_LINES   = 7,
  parameter int ID_W        = 32,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LVL_W-1:0]     cfg_level,
  input  logic [7:0]           cfg_laddr,
  input  logic [7:0]           cfg_cause,
  input  logic [15:0]          cfg_devdep,
  input  logic                 event_i,
  input  logic                 ack_in_n,
  input  logic [LVL_W-1:0]     ack_lvl,
  output logic [NUM_LINES-1:0] irq_n,
  output logic                 ack_out_n,
  output logic [ID_W-1:0]      data_o,
  output logic                 data_oe,
  output logic                 dtack_n
);
  logic ack_s, pending, grant, busy, resp, fwd;

  irqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(!ack_in_n), .q_o(ack_s)
  );

  irqc_request #(.NUM_LINES(NUM_LINES)) u_req (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .event_i(event_i),
    .busy_i(busy), .grant_i(grant), .pending_o(pending), .irq_n(irq_n)
  );

  irqc_ack_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ack_s(ack_s), .ack_lvl(ack_lvl),
    .cfg_level(cfg_level), .pending_i(pending), .grant_o(grant),
    .busy_o(busy), .resp_o(resp), .fwd_o(fwd)
  );

  irqc_status_fmt #(.ID_W(ID_W)) u_fmt (
    .laddr(cfg_laddr), .cause(cfg_cause), .devdep(cfg_devdep),
    .drive_i(resp), .data_o(data_o)
  );

  assign data_oe   = resp;
  assign dtack_n   = !resp;
  assign ack_out_n = !fwd;

  // R3: responding and forwarding are exclusive
  a_r3_absorb: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !ack_out_n));
  // R6: request line released once response starts
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dtack_n) |-> (&irq_n));
  // R7: outputs drop once the synchronized acknowledge is gone
  a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_s) |-> (dtack_n && ack_out_n && !data_oe));
  // R9: data lines quiet when not driving
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> (data_o == '0));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [2:0]  cfg_level, ack_lvl;
  logic [7:0]  cfg_laddr, cfg_cause;
  logic [15:0] cfg_devdep;
  logic        event_i, ack_in_n;
  logic [6:0]  irq_n, irq_n8, irq_n16;
  logic        ack_out_n, data_oe, dtack_n;
  logic        ack_out_n8, data_oe8, dtack_n8, ack_out_n16, data_oe16, dtack_n16;
  logic [31:0] data_o;
  logic [7:0]  data_o8;
  logic [15:0] data_o16;

  irqc_top #(.ID_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_laddr(cfg_laddr),
    .cfg_cause(cfg_cause), .cfg_devdep(cfg_devdep), .event_i(event_i),
    .ack_in_n(ack_in_n), .ack_lvl(ack_lvl), .irq_n(irq_n),
    .ack_out_n(ack_out_n), .data_o(data_o), .data_oe(data_oe), .dtack_n(dtack_n)
  );
  irqc_top #(.ID_W(8)) u_dut8 (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_laddr(cfg_laddr),
    .cfg_cause(cfg_cause), .cfg_devdep(cfg_devdep), .event_i(event_i),
    .ack_in_n(ack_in_n), .ack_lvl(ack_lvl), .irq_n(irq_n8),
    .ack_out_n(ack_out_n8), .data_o(data_o8), .data_oe(data_oe8), .dtack_n(dtack_n8)
  );
  irqc_top #(.ID_W(16)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_laddr(cfg_laddr),
    .cfg_cause(cfg_cause), .cfg_devdep(cfg_devdep), .event_i(event_i),
    .ack_in_n(ack_in_n), .ack_lvl(ack_lvl), .irq_n(irq_n16),
    .ack_out_n(ack_out_n16), .data_o(data_o16), .data_oe(data_oe16), .dtack_n(dtack_n16)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit pend_m = 1'b0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] exp_irq(bit p, logic [2:0] lvl);
    logic [6:0] v = 7'h7f;
    if (p && lvl != 3'd0) v[lvl-1] = 1'b0;
    return v;
  endfunction

  function automatic logic [31:0] exp_id32(logic [15:0] dd, logic [7:0] c, logic [7:0] la);
    return {dd, c, la};
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_trial(logic [2:0] lvl, logic [2:0] alvl, bit do_evt, bit evt_during);
    bit hit;
    cfg_level  = lvl;
    cfg_laddr  = 8'($urandom);
    cfg_cause  = 8'($urandom);
    cfg_devdep = 16'($urandom);
    if (do_evt) begin
      event_i = 1'b1; cyc(1); event_i = 1'b0;
      pend_m = 1'b1;
    end else cyc(1);
    check(irq_n == exp_irq(pend_m, lvl), "R2", 32'(irq_n), 32'(exp_irq(pend_m, lvl)));
    ack_lvl = alvl; ack_in_n = 1'b0;
    cyc(2);
    check(dtack_n && ack_out_n, "R3 timing", {dtack_n, ack_out_n}, 32'h3);
    cyc(1);
    hit = pend_m && (lvl == alvl) && (lvl != 3'd0);
    if (hit) pend_m = 1'b0;
    check(dtack_n == !hit && data_oe == hit, hit ? "R3" : "R4", {dtack_n, data_oe}, {!hit, hit});
    check(ack_out_n == hit, hit ? "R3 absorb" : "R4 fwd", 32'(ack_out_n), 32'(hit));
    check(data_o == (hit ? exp_id32(cfg_devdep, cfg_cause, cfg_laddr) : 32'h0),
          hit ? "R5" : "R9", data_o, hit ? exp_id32(cfg_devdep, cfg_cause, cfg_laddr) : 0);
    if (hit) begin
      check(data_o8 == cfg_laddr, "R5 w8", 32'(data_o8), 32'(cfg_laddr));
      check(data_o16 == {cfg_cause, cfg_laddr}, "R5 w16", 32'(data_o16), {16'h0, cfg_cause, cfg_laddr});
    end
    check(irq_n == exp_irq(pend_m, lvl), "R6", 32'(irq_n), 32'(exp_irq(pend_m, lvl)));
    if (evt_during) begin
      event_i = 1'b1; cyc(1); event_i = 1'b0;
      cyc(1);
      check(irq_n == exp_irq(pend_m, lvl), "R8 held", 32'(irq_n), 32'(exp_irq(pend_m, lvl)));
    end
    ack_in_n = 1'b1;
    cyc(1);
    check(hit ? !dtack_n : !ack_out_n, "R7 not early", {dtack_n, ack_out_n}, 32'h0);
    cyc(1);
    check(dtack_n && ack_out_n && !data_oe, "R7", {dtack_n, ack_out_n, data_oe}, 32'h6);
    check(irq_n == exp_irq(pend_m, lvl), "R8 still held", 32'(irq_n), 32'(exp_irq(pend_m, lvl)));
    cyc(1);
    check(irq_n == exp_irq(pend_m, lvl), "R8 edge3", 32'(irq_n), 32'(exp_irq(pend_m, lvl)));
    cyc(1);
    if (evt_during) pend_m = 1'b1;
    check(irq_n == exp_irq(pend_m, lvl), "R8 after", 32'(irq_n), 32'(exp_irq(pend_m, lvl)));
    cyc(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_level = 3'd3; ack_lvl = 3'd0; cfg_laddr = 8'h00;
    cfg_cause = 8'h00; cfg_devdep = 16'h0; event_i = 1'b0; ack_in_n = 1'b1;
    cyc(3);
    check(irq_n == 7'h7f && ack_out_n && dtack_n && !data_oe && data_o == 0, "R1 in reset",
          {irq_n, ack_out_n, dtack_n, data_oe}, {7'h7f, 3'b110});
    rst_n = 1'b1;
    cyc(2);
    check(irq_n == 7'h7f && ack_out_n && dtack_n && !data_oe, "R1 after reset",
          {irq_n, ack_out_n, dtack_n, data_oe}, {7'h7f, 3'b110});
    // directed corners
    run_trial(3'd7, 3'd7, 1'b1, 1'b0);   // R3 top level responds
    run_trial(3'd1, 3'd2, 1'b1, 1'b0);   // R4 wrong level forwards
    run_trial(3'd1, 3'd1, 1'b0, 1'b0);   // R3 still pending from before
    run_trial(3'd4, 3'd4, 1'b0, 1'b0);   // R4 nothing pending forwards
    run_trial(3'd0, 3'd0, 1'b1, 1'b0);   // R2 disabled level pulls nothing
    run_trial(3'd5, 3'd5, 1'b0, 1'b1);   // R8 event during response
    run_trial(3'd5, 3'd2, 1'b0, 1'b1);   // R8 event during forward
    run_trial(3'd5, 3'd5, 1'b0, 1'b0);   // R6 service clears request
    for (int i = 0; i < 150; i++) begin
      logic [2:0] l = 3'($urandom_range(7, 0));
      logic [2:0] a = ($urandom_range(1, 0) != 0) ? l : 3'($urandom_range(7, 1));
      run_trial(l, a, $urandom_range(1, 0) != 0, $urandom_range(3, 0) == 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule